// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a 16-pin general-purpose I/O port on a simple APB-style peripheral bus. Software writes an output latch that drives the pins, and it reads back the input pin levels after a two-stage synchronizer. Five per-pin configuration masks are each changed only through a pair of addresses: one where a 1 in the written word sets the bit and one where a 1 clears it. The five masks are output enable, alternate-function select, interrupt enable, interrupt type and interrupt polarity. Both addresses of a pair read back the current mask.

Every pin has its own interrupt detector. In level mode the detector flags an enabled pin while the pin is at its active level. In edge mode it latches an enabled rising or falling transition and holds it until software clears it. The status bits go to the interrupt controller as per-pin lines and as one combined line. A single offset returns the status on a read and clears status bits on a write. A fixed block of identification words sits at the top of the 4 KB window.

Top module: `gpio_port_apb`

## Requirements
- R1: After a synchronous active-low reset, the output latch, all five configuration masks and all status bits are zero, so `pin_out`, `pin_oe`, `alt_sel`, `irq_pin` and `irq_any` are all low.
- R2: A write to offset 0x004 loads the output latch from `pwdata[15:0]`. The latch drives `pin_out` from the next cycle and reads back at 0x004.
- R3: Writing a mask to a set offset ORs it into its configuration mask, and writing to the matching clear offset removes the mask bits. Zero bits leave the mask unchanged. The offset pairs are: output enable at 0x010/0x014 (drives `pin_oe`), alternate select at 0x018/0x01C (drives `alt_sel`), interrupt enable at 0x020/0x024, interrupt type at 0x028/0x02C and interrupt polarity at 0x030/0x034. Either address of a pair reads the current mask.
- R4: A read at offset 0x000 returns the pin levels through two flops. A change on `pin_in` before clock edge k shows up after edge k+1 and not after edge k.
- R5: With type bit 1 (edge mode), polarity bit 1 latches a status bit on a rising edge and polarity bit 0 on a falling edge. The latched bit stays set after the pin returns to its earlier level.
- R6: A pin whose interrupt-enable bit is 0 never sets its status bit. A pin whose enable has been cleared at 0x024 no longer sets it either.
- R7: A read of offset 0x038 returns the per-pin status. A write there clears each edge-mode status bit whose mask bit is 1 and leaves the other bits set.
- R8: If an enabled edge is detected in the same cycle that a clear for that pin is written, the status bit stays set.
- R9: With type bit 0 (level mode), the status bit is 1 exactly while an enabled pin sits at its active level (high for polarity 1, low for polarity 0). It is delayed by the synchronizer and one register, and a clear write does not drop it while the level persists.
- R10: `irq_pin` carries the status bits and `irq_any` is high whenever any status bit is set.
- R11: Offsets 0x008, 0x00C and every other unmapped or non-word-aligned address read as zero, and writes to them change no state.
- R12: The identification words are read-only and return these low bytes: 0xFD0=0x04, 0xFE0=0x21, 0xFE4=0xB8, 0xFE8=0x1B, 0xFEC=0x00, 0xFF0=0x0D, 0xFF4=0xF0, 0xFF8=0x05, 0xFFC=0xB1. Their upper bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase of a transfer |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while selected for a read |
| pin_in | input | 16 | Asynchronous pin levels from the pads |
| pin_out | output | 16 | Output latch to the pads |
| pin_oe | output | 16 | Per-pin output enable |
| alt_sel | output | 16 | Per-pin alternate-function select |
| irq_pin | output | 16 | Per-pin interrupt status |
| irq_any | output | 1 | OR of all interrupt status bits |

## Verification
Register writes take effect at the edge that ends the access phase, so every readback and every `pin_out`/`pin_oe` check is made at least one falling edge after that. The pin path adds latency on top of this. The input level is due two rising edges after a pin change, and the bench checks that it is not yet visible after one. A status bit is due three edges after the change, and the bench waits four cycles before it reads a status. The test for a clear that lands together with an edge times the write so that the clear commits on the third edge after the pin change, which is the cycle in which the edge is detected.

// File: rtl/gpio_port_pkg.sv
// Shared constants for the GPIO port: word indices of the register map,
// configuration mask numbering and the identification constants.
package gpio_port_pkg;

    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 32;
    localparam int WIDX_W     = ADDR_W - 2;
    localparam int CFG_FIELDS = 5;

    // Word indices (byte offset / 4)
    localparam logic [WIDX_W-1:0] WI_PINS     = 10'h000;
    localparam logic [WIDX_W-1:0] WI_LATCH    = 10'h001;
    localparam logic [WIDX_W-1:0] WI_CFG_BASE = 10'h004;
    localparam logic [WIDX_W-1:0] WI_IRQ_STAT = 10'h00E;

    // Configuration mask numbering; mask k is set at CFG_BASE+2k, cleared at +1
    localparam int CFG_OE    = 0;
    localparam int CFG_ALT   = 1;
    localparam int CFG_IEN   = 2;
    localparam int CFG_ITYPE = 3;
    localparam int CFG_IPOL  = 4;

    // Identification byte for a word index; zero for any non-ident word
    function automatic logic [7:0] ident_byte(input logic [WIDX_W-1:0] w);
        case (w)
            10'h3F4: ident_byte = 8'h04;
            10'h3F8: ident_byte = 8'h21;
            10'h3F9: ident_byte = 8'hB8;
            10'h3FA: ident_byte = 8'h1B;
            10'h3FB: ident_byte = 8'h00;
            10'h3FC: ident_byte = 8'h0D;
            10'h3FD: ident_byte = 8'hF0;
            10'h3FE: ident_byte = 8'h05;
            10'h3FF: ident_byte = 8'hB1;
            default: ident_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
// Two-flop synchronizer for the pin inputs, plus a third stage holding the
// previous synchronized sample for edge detection.
// Assumes pin_in is asynchronous to clk; each bit is synchronized separately.
module gpio_in_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_prev
);
    logic [W-1:0] stage1;

    // Shift the pin levels through the synchronizer and history stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            lvl      <= '0;
            lvl_prev <= '0;
        end else begin
            stage1   <= pin_in;
            lvl      <= stage1;
            lvl_prev <= lvl;
        end
    end
endmodule

// File: rtl/gpio_irq_detect.sv
// Per-pin interrupt detectors. Edge mode latches an enabled transition of
// the selected direction until cleared, and a new edge wins over a clear in
// the same cycle. Level mode tracks the enabled active level and ignores clears.
// Assumes lvl/lvl_prev come from the synchronizer.
module gpio_irq_detect #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] lvl_prev,
    input  logic [W-1:0] en,
    input  logic [W-1:0] edge_mode,
    input  logic [W-1:0] pol_high,
    input  logic         clr_we,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status
);
    logic [W-1:0] status_d;

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise, fall, edge_hit, level_hit, kept;
        // Edge and level qualifiers for this pin
        assign rise      = lvl[i] & ~lvl_prev[i];
        assign fall      = ~lvl[i] & lvl_prev[i];
        assign edge_hit  = en[i] & (pol_high[i] ? rise : fall);
        assign level_hit = en[i] & (lvl[i] == pol_high[i]);
        assign kept      = status[i] & ~(clr_we & clr_mask[i]);
        assign status_d[i] = edge_mode[i] ? (kept | edge_hit) : level_hit;
    end

    // Register the status bits
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= status_d;
    end
endmodule

// File: rtl/gpio_apb_regs.sv
// Bus slave and register file of the GPIO port: output latch, five
// set/clear configuration masks, status read/clear and identification words.
// Assumes zero wait states: writes commit at the access-phase edge and read
// data is combinational while selected for a read.
module gpio_apb_regs
    import gpio_port_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [ADDR_W-1:0]    paddr,
    input  logic [DATA_W-1:0]    pwdata,
    output logic [DATA_W-1:0]    prdata,
    input  logic [W-1:0]         pins_lvl,
    input  logic [W-1:0]         irq_stat,
    output logic [W-1:0]         latch_q,
    output logic [W-1:0]         cfg_q [CFG_FIELDS],
    output logic                 clr_we,
    output logic [W-1:0]         clr_mask
);
    logic [WIDX_W-1:0] word;
    logic              aligned;
    logic              wr;
    logic [W-1:0]      wdata;
    logic [W-1:0]      cfg_d [CFG_FIELDS];
    logic [W-1:0]      rd_w;
    logic              rd_ident;

    assign word    = paddr[ADDR_W-1:2];
    assign aligned = (paddr[1:0] == 2'b00);
    assign wr      = psel & penable & pwrite & aligned;
    assign wdata   = pwdata[W-1:0];

    if (W < DATA_W) begin : g_unused
        logic unused_hi;
        assign unused_hi = ^pwdata[DATA_W-1:W];
    end

    assign clr_we   = wr && (word == WI_IRQ_STAT);
    assign clr_mask = wdata;

    // Output latch update
    always_ff @(posedge clk) begin
        if (!rst_n)                         latch_q <= '0;
        else if (wr && word == WI_LATCH)    latch_q <= wdata;
    end

    for (genvar k = 0; k < CFG_FIELDS; k++) begin : g_cfg
        localparam logic [WIDX_W-1:0] SET_W = WI_CFG_BASE + WIDX_W'(2 * k);
        localparam logic [WIDX_W-1:0] CLR_W = WI_CFG_BASE + WIDX_W'(2 * k + 1);
        logic set_hit, clr_hit;
        // Decode this mask's set and clear strobes and form its next value
        assign set_hit  = wr && (word == SET_W);
        assign clr_hit  = wr && (word == CLR_W);
        assign cfg_d[k] = set_hit ? (cfg_q[k] | wdata)
                        : clr_hit ? (cfg_q[k] & ~wdata)
                        : cfg_q[k];
    end

    // Register all configuration masks
    always_ff @(posedge clk) begin
        for (int k = 0; k < CFG_FIELDS; k++) begin
            if (!rst_n) cfg_q[k] <= '0;
            else        cfg_q[k] <= cfg_d[k];
        end
    end

    // Select the read word for the addressed register
    always_comb begin
        rd_w     = '0;
        rd_ident = 1'b0;
        if (word == WI_PINS)          rd_w = pins_lvl;
        else if (word == WI_LATCH)    rd_w = latch_q;
        else if (word == WI_IRQ_STAT) rd_w = irq_stat;
        else                          rd_ident = 1'b1;
        for (int k = 0; k < CFG_FIELDS; k++) begin
            if (word == WI_CFG_BASE + WIDX_W'(2 * k) ||
                word == WI_CFG_BASE + WIDX_W'(2 * k + 1)) begin
                rd_w     = cfg_q[k];
                rd_ident = 1'b0;
            end
        end
    end

    // Drive read data only for aligned, selected reads
    always_comb begin
        prdata = '0;
        if (psel && !pwrite && aligned) begin
            if (rd_ident) prdata = DATA_W'(ident_byte(word));
            else          prdata = DATA_W'(rd_w);
        end
    end
endmodule

// File: rtl/gpio_port_apb.sv
// Top of the GPIO port: bus register file, input synchronizer and per-pin
// interrupt detectors. Assumes a single clock and synchronous active-low reset.
module gpio_port_apb
    import gpio_port_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [11:0]       paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    output logic [W-1:0]      alt_sel,
    output logic [W-1:0]      irq_pin,
    output logic              irq_any
);
    logic [W-1:0] lvl, lvl_prev;
    logic [W-1:0] cfg_q [CFG_FIELDS];
    logic         clr_we;
    logic [W-1:0] clr_mask;
    logic [W-1:0] status;
    logic [W-1:0] cfg_en, cfg_type;

    gpio_apb_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .pwdata   (pwdata),
        .prdata   (prdata),
        .pins_lvl (lvl),
        .irq_stat (status),
        .latch_q  (pin_out),
        .cfg_q    (cfg_q),
        .clr_we   (clr_we),
        .clr_mask (clr_mask)
    );

    gpio_in_sync #(.W(W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .lvl      (lvl),
        .lvl_prev (lvl_prev)
    );

    assign cfg_en   = cfg_q[CFG_IEN];
    assign cfg_type = cfg_q[CFG_ITYPE];

    gpio_irq_detect #(.W(W)) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl       (lvl),
        .lvl_prev  (lvl_prev),
        .en        (cfg_en),
        .edge_mode (cfg_type),
        .pol_high  (cfg_q[CFG_IPOL]),
        .clr_we    (clr_we),
        .clr_mask  (clr_mask),
        .status    (status)
    );

    assign pin_oe  = cfg_q[CFG_OE];
    assign alt_sel = cfg_q[CFG_ALT];
    assign irq_pin = status;
    assign irq_any = |status;
endmodule

// File: rtl/gpio_port_checker.sv
// Assertion checker for gpio_port_apb, attached with bind below.
// Observes the bus, the outputs and the enable/type masks.
module gpio_port_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         psel,
    input logic         penable,
    input logic         pwrite,
    input logic [11:0]  paddr,
    input logic [31:0]  pwdata,
    input logic [W-1:0] pin_out,
    input logic [W-1:0] pin_oe,
    input logic [W-1:0] irq_pin,
    input logic [W-1:0] cfg_en,
    input logic [W-1:0] cfg_type
);
    logic wr;
    assign wr = psel && penable && pwrite;

    // R2: latch write shows on pin_out next cycle
    p_latch_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && paddr == 12'h004) |=> (pin_out == $past(pwdata[W-1:0])));

    // R3: set address ORs the mask into output enable
    p_oe_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && paddr == 12'h010) |=> (pin_oe == ($past(pin_oe) | $past(pwdata[W-1:0]))));

    // R3: clear address removes mask bits from output enable
    p_oe_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && paddr == 12'h014) |=> (pin_oe == ($past(pin_oe) & ~$past(pwdata[W-1:0]))));

    for (genvar i = 0; i < W; i++) begin : g_bit
        // R5: latched edge status holds while no bus write happens
        p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_type[i] && irq_pin[i] && !wr) |=> irq_pin[i]);

        // R6: a disabled pin cannot raise its status
        p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_en[i] && !irq_pin[i]) |=> !irq_pin[i]);
    end
endmodule

bind gpio_port_apb gpio_port_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .irq_pin  (irq_pin),
    .cfg_en   (cfg_en),
    .cfg_type (cfg_type)
);

// File: tb/tb_gpio_port_apb.sv
`timescale 1ns/1ps
module tb_gpio_port_apb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe, alt_sel, irq_pin;
    logic        irq_any;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_port_apb dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .alt_sel(alt_sel),
        .irq_pin(irq_pin), .irq_any(irq_any)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge clk); penable = 1; d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic set_pins(input logic [15:0] v);
        @(negedge clk); pin_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 pin_out", 32'(pin_out), 0);
        chk("R1 pin_oe", 32'(pin_oe), 0);
        chk("R1 alt_sel", 32'(alt_sel), 0);
        chk("R1 irq", {15'd0, irq_any, irq_pin}, 0);
        rd_chk("R1 latch", 12'h004, 0);
        for (int k = 0; k < 5; k++) rd_chk("R1 cfg", 12'h010 + 12'(8 * k), 0);
    endtask

    task automatic t_output();
        wr(12'h004, 32'hFFFF_A5C3);
        chk("R2 pin_out", 32'(pin_out), 32'h0000_A5C3);
        rd_chk("R2 readback", 12'h004, 32'h0000_A5C3);
    endtask

    task automatic t_setclr();
        wr(12'h010, 32'h00FF);
        wr(12'h010, 32'h0F00);
        chk("R3 oe set", 32'(pin_oe), 32'h0FFF);
        wr(12'h014, 32'h0011);
        chk("R3 oe clr", 32'(pin_oe), 32'h0FEE);
        rd_chk("R3 oe read clr addr", 12'h014, 32'h0FEE);
        wr(12'h018, 32'h8001);
        rd_chk("R3 alt read", 12'h01C, 32'h8001);
        wr(12'h01C, 32'h0001);
        chk("R3 alt clr", 32'(alt_sel), 32'h8000);
        wr(12'h010, 32'h0);
        chk("R3 zero mask", 32'(pin_oe), 32'h0FEE);
    endtask

    task automatic t_input();
        @(negedge clk); psel = 1; pwrite = 0; paddr = 12'h000; penable = 0;
        pin_in = 16'h1234;
        @(negedge clk);
        chk("R4 one edge", prdata, 32'h0);
        @(negedge clk);
        chk("R4 two edges", prdata, 32'h1234);
        psel = 0;
        set_pins(16'h0000);
        rd_chk("R4 back low", 12'h000, 32'h0);
    endtask

    task automatic t_edge();
        wr(12'h028, 32'h0003);           // edge mode pins 0,1
        wr(12'h030, 32'h0001);           // pin0 rising, pin1 falling
        wr(12'h020, 32'h0003);
        set_pins(16'h0002);              // pin1 rises: no status
        rd_chk("R5 rise on falling pin", 12'h038, 32'h0);
        set_pins(16'h0003);              // pin0 rises
        set_pins(16'h0002);
        rd_chk("R5 rising latched", 12'h038, 32'h1);
        set_pins(16'h0000);              // pin1 falls
        rd_chk("R5 falling latched", 12'h038, 32'h3);
        chk("R10 lines", {15'd0, irq_any, irq_pin}, 32'h0001_0003);
        wr(12'h038, 32'h0001);
        rd_chk("R7 partial clear", 12'h038, 32'h2);
        wr(12'h038, 32'h0002);
        chk("R10 any low", {15'd0, irq_any, irq_pin}, 0);
    endtask

    task automatic t_disabled();
        wr(12'h028, 32'h0004);
        wr(12'h030, 32'h0004);           // pin2 rising, not enabled
        set_pins(16'h0004);
        set_pins(16'h0000);
        rd_chk("R6 not enabled", 12'h038, 32'h0);
        wr(12'h024, 32'h0001);           // disable pin0
        set_pins(16'h0001);
        set_pins(16'h0000);
        rd_chk("R6 disabled by clear", 12'h038, 32'h0);
    endtask

    task automatic t_coincide();
        set_pins(16'h0002);
        set_pins(16'h0000);              // pin1 falling -> set
        rd_chk("R8 preset", 12'h038, 32'h2);
        set_pins(16'h0002);
        @(negedge clk); pin_in = 16'h0000;
        @(posedge clk);
        @(negedge clk); psel = 1; pwrite = 1; paddr = 12'h038; pwdata = 32'h2; penable = 0;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
        rd_chk("R8 edge beats clear", 12'h038, 32'h2);
        wr(12'h038, 32'h2);
        rd_chk("R8 clear later", 12'h038, 32'h0);
    endtask

    task automatic t_level();
        wr(12'h030, 32'h0008);           // pin3 active high, level mode
        wr(12'h020, 32'h0008);
        rd_chk("R9 low inactive", 12'h038, 32'h0);
        set_pins(16'h0008);
        rd_chk("R9 high active", 12'h038, 32'h8);
        wr(12'h038, 32'h0008);
        rd_chk("R9 clear ignored", 12'h038, 32'h8);
        set_pins(16'h0000);
        rd_chk("R9 follows level", 12'h038, 32'h0);
        wr(12'h020, 32'h0010);           // pin4 active low, pin low
        repeat (3) @(negedge clk);
        rd_chk("R9 active low", 12'h038, 32'h10);
        set_pins(16'h0010);
        rd_chk("R9 active low released", 12'h038, 32'h0);
        chk("R10 idle", 32'(irq_any), 0);
    endtask

    task automatic t_reserved();
        wr(12'h008, 32'hFFFF);
        wr(12'h00C, 32'hFFFF);
        wr(12'h006, 32'h1111);
        rd_chk("R11 0x008", 12'h008, 0);
        rd_chk("R11 0x00C", 12'h00C, 0);
        rd_chk("R11 unmapped", 12'h100, 0);
        rd_chk("R11 misaligned", 12'h005, 0);
        rd_chk("R11 latch intact", 12'h004, 32'h0000_A5C3);
        chk("R11 oe intact", 32'(pin_oe), 32'h0FEE);
    endtask

    task automatic t_ident();
        rd_chk("R12 FD0", 12'hFD0, 32'h04);
        rd_chk("R12 FE0", 12'hFE0, 32'h21);
        rd_chk("R12 FE4", 12'hFE4, 32'hB8);
        rd_chk("R12 FE8", 12'hFE8, 32'h1B);
        rd_chk("R12 FEC", 12'hFEC, 32'h00);
        rd_chk("R12 FF0", 12'hFF0, 32'h0D);
        rd_chk("R12 FF4", 12'hFF4, 32'hF0);
        rd_chk("R12 FF8", 12'hFF8, 32'h05);
        rd_chk("R12 FFC", 12'hFFC, 32'hB1);
        wr(12'hFD0, 32'hFFFF);
        rd_chk("R12 read-only", 12'hFD0, 32'h04);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_output();
        t_setclr();
        t_input();
        t_edge();
        t_disabled();
        t_coincide();
        t_level();
        t_reserved();
        t_ident();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule